// File: doc/BRIEF.md
# First-Layer Binary-Weight MAC Core

This core computes one output activation of the first layer of a binarized convolutional network. The activations entering that layer are still 8-bit signed integers, while its weights are already single bits. On each accepted beat, the core takes a vector of `LANES` pixels and an equally wide word of weight bits. A lane whose weight bit is set contributes its pixel unchanged. A lane whose weight bit is clear contributes the pixel negated. A pipelined adder tree reduces the lane contributions, and an accumulator sums them over every beat of a filter window.

The filter's threshold is held in a register that is loaded through a small port. It is not compared against the result at the end. Instead it is folded into the accumulator: the first beat of every window starts from the negated threshold. The final decision is therefore only the sign of the accumulator. When the beat flagged as last reaches the accumulator, the core emits one activation bit with a single-cycle valid. It then restarts on the very next beat, so windows can follow each other with no idle cycle. The surrounding address generators, feature memories and weight buffers feed the pixel and weight inputs.

Top module: `flmac_core`

## Requirements
- R1: Each lane of `pix_data` is an 8-bit two's-complement pixel in the range -127 to 127. Lane j occupies bits [8j+7:8j] and pairs with weight bit j of `wgt_bits`. The value -128 is outside the input contract.
- R2: A weight bit of 1 makes its lane contribute +pixel. A weight bit of 0 makes it contribute -pixel. Negating -127 yields +127.
- R3: The activation for a window is based on the sum of all lane contributions over every accepted beat of that window. A beat is accepted when `pix_valid` is 1, and the window ends with the accepted beat that has `pix_last` = 1.
- R4: `act_bit` is 1 when the window sum is greater than or equal to the signed threshold, and 0 when it is smaller. A sum exactly equal to the threshold gives 1.
- R5: A cycle with `tau_load` = 1 stores `tau_value` as a 16-bit signed threshold. The stored threshold applies to every window whose first beat is accepted after the load, once the pipeline is empty.
- R6: For every accepted last beat, `act_valid` is 1 for exactly one cycle, `PIPE ? clog2(LANES) : 0` + 1 cycles after the clock edge that accepts that beat. `act_valid` is never asserted otherwise.
- R7: A window may start on the cycle right after the previous window's last beat. The new window starts again from the threshold and carries nothing over from the previous window.
- R8: Cycles with `pix_valid` = 0 inside or between windows leave the sum unchanged, whatever `pix_data`, `wgt_bits` and `pix_last` carry.
- R9: Windows of up to `MAX_BEATS` beats are summed exactly at full scale, with every pixel at ±127 and any 16-bit threshold, with no wrap-around.
- R10: After reset, `act_valid` is 0 and the stored threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Beat on `pix_data`/`wgt_bits` is accepted this cycle |
| pix_last | input | 1 | Accepted beat closes the current window |
| pix_data | input | LANES*8 | Signed pixels, lane j at bits [8j+7:8j] |
| wgt_bits | input | LANES | Weight bit per lane, 1 = +1, 0 = -1 |
| tau_load | input | 1 | Store `tau_value` as the threshold |
| tau_value | input | 16 | Signed threshold |
| act_valid | output | 1 | One-cycle pulse carrying a finished activation |
| act_bit | output | 1 | Binarized activation, 1 when sum >= threshold |

## Verification
The bench first targets the threshold boundary. It uses single-beat windows whose sums land exactly on the threshold and one below it, so a comparison written as strictly greater, or a threshold folded with the wrong sign, gives a wrong bit. Full-scale windows of `MAX_BEATS` beats at +127 and at -127, with both weight polarities and extreme thresholds, catch an accumulator that is too narrow: its sum would wrap and flip the bit. Random windows run back to back with no idle cycle and carry random invalid gaps full of garbage data. These would expose a missed reload, where the previous window's sum or the threshold is reused, and also any leakage of unaccepted beats. Every result is matched against its expected cycle, so a pipeline whose valid and data drift apart is also reported.

// File: rtl/flmac_pkg.sv
package flmac_pkg;

   // Width needed to hold +/- (lanes*pix_max*beats + 2**(tau_w-1)) in two's complement.
   function automatic int acc_width(input int lanes, input int pix_max,
                                    input int beats, input int tau_w);
      longint span;
      span = longint'(lanes) * longint'(pix_max) * longint'(beats)
             + (longint'(1) << (tau_w - 1));
      return $clog2(span + 1) + 1;
   endfunction

   // Number of adder-tree levels for a lane count (at least one).
   function automatic int tree_levels(input int lanes);
      return (lanes < 2) ? 1 : $clog2(lanes);
   endfunction

endpackage

// File: rtl/flmac_lane.sv
// Per-lane conditional negation and sign extension into the tree leaf vector.
module flmac_lane #(
   parameter int LANES  = 8,
   parameter int PIX_W  = 8,
   parameter int LEAVES = 8,
   parameter int SUM_W  = 11
) (
   input  logic [LANES*PIX_W-1:0]  pix_data,
   input  logic [LANES-1:0]        wgt_bits,
   output logic [LEAVES*SUM_W-1:0] leaves
);

   localparam int EXT_W = SUM_W - PIX_W;

   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < LANES) begin : g_used
         logic signed [PIX_W-1:0] pix;
         logic signed [PIX_W-1:0] term;
         assign pix  = pix_data[j*PIX_W +: PIX_W];
         // -127 is the lowest legal input, so the negation stays in PIX_W bits.
         assign term = wgt_bits[j] ? pix : -pix;
         assign leaves[j*SUM_W +: SUM_W] = {{EXT_W{term[PIX_W-1]}}, term};
      end else begin : g_pad
         assign leaves[j*SUM_W +: SUM_W] = '0;
      end
   end

endmodule

// File: rtl/flmac_tree.sv
// Binary adder tree; PIPE selects a register after every level or a purely combinational tree.
module flmac_tree #(
   parameter int LEVELS = 3,
   parameter int SUM_W  = 11,
   parameter bit PIPE   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_vld,
   input  logic                           in_last,
   input  logic [(1<<LEVELS)*SUM_W-1:0]   leaves,
   output logic                           out_vld,
   output logic                           out_last,
   output logic signed [SUM_W-1:0]        out_sum
);

   localparam int LEAVES = 1 << LEVELS;

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int NODES = LEAVES >> l;
      logic [NODES*SUM_W-1:0] lv_d;
      logic                   lv_v;
      logic                   lv_l;

      if (l == 0) begin : g_root
         assign lv_d = leaves;
         assign lv_v = in_vld;
         assign lv_l = in_last;
      end else begin : g_add
         logic [NODES*SUM_W-1:0] comb;
         always_comb begin
            for (int n = 0; n < NODES; n++) begin
               comb[n*SUM_W +: SUM_W] =
                  $signed(g_lvl[l-1].lv_d[(2*n)*SUM_W +: SUM_W]) +
                  $signed(g_lvl[l-1].lv_d[(2*n+1)*SUM_W +: SUM_W]);
            end
         end

         if (PIPE) begin : g_reg
            logic [NODES*SUM_W-1:0] d_q;
            logic                   v_q;
            logic                   l_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  v_q <= 1'b0;
                  l_q <= 1'b0;
               end else begin
                  v_q <= g_lvl[l-1].lv_v;
                  l_q <= g_lvl[l-1].lv_l;
               end
            end
            always_ff @(posedge clk) begin
               d_q <= comb;
            end
            assign lv_d = d_q;
            assign lv_v = v_q;
            assign lv_l = l_q;
         end else begin : g_wire
            assign lv_d = comb;
            assign lv_v = g_lvl[l-1].lv_v;
            assign lv_l = g_lvl[l-1].lv_l;
         end
      end
   end

   assign out_sum  = g_lvl[LEVELS].lv_d;
   assign out_vld  = g_lvl[LEVELS].lv_v;
   assign out_last = g_lvl[LEVELS].lv_l;

endmodule

// File: rtl/flmac_acc.sv
// Window accumulator seeded with the negated threshold; emits the sign decision on the last beat.
module flmac_acc #(
   parameter int SUM_W = 11,
   parameter int TAU_W = 16,
   parameter int ACC_W = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sum_vld,
   input  logic                    sum_last,
   input  logic signed [SUM_W-1:0] sum,
   input  logic [TAU_W-1:0]        tau,
   output logic                    act_valid,
   output logic                    act_bit
);

   logic                    fresh_q;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] tau_ext;
   logic signed [ACC_W-1:0] sum_ext;
   logic signed [ACC_W-1:0] base;
   logic signed [ACC_W-1:0] nxt;

   assign tau_ext = {{(ACC_W-TAU_W){tau[TAU_W-1]}}, tau};
   assign sum_ext = {{(ACC_W-SUM_W){sum[SUM_W-1]}}, sum};

   always_comb begin
      base = fresh_q ? -tau_ext : acc_q;
      nxt  = base + sum_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q   <= 1'b1;
         acc_q     <= '0;
         act_valid <= 1'b0;
         act_bit   <= 1'b0;
      end else begin
         act_valid <= sum_vld && sum_last;
         if (sum_vld) begin
            if (sum_last) begin
               act_bit <= ~nxt[ACC_W-1];
               fresh_q <= 1'b1;
            end else begin
               acc_q   <= nxt;
               fresh_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/flmac_core.sv
// First-layer MAC core: 8-bit pixels, 1-bit weights, threshold folded into the accumulator.
module flmac_core #(
   parameter int LANES     = 8,
   parameter int PIX_W     = 8,
   parameter int TAU_W     = 16,
   parameter int MAX_BEATS = 64,
   parameter bit PIPE      = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pix_valid,
   input  logic                   pix_last,
   input  logic [LANES*PIX_W-1:0] pix_data,
   input  logic [LANES-1:0]       wgt_bits,
   input  logic                   tau_load,
   input  logic [TAU_W-1:0]       tau_value,
   output logic                   act_valid,
   output logic                   act_bit
);

   import flmac_pkg::*;

   localparam int PIX_MAX = (1 << (PIX_W - 1)) - 1;
   localparam int LEVELS  = tree_levels(LANES);
   localparam int LEAVES  = 1 << LEVELS;
   localparam int SUM_W   = PIX_W + LEVELS;
   localparam int ACC_W   = acc_width(LANES, PIX_MAX, MAX_BEATS, TAU_W);

   initial begin : p_param_chk
      assert (LANES >= 2)       else $error("flmac_core: LANES must be at least 2");
      assert (PIX_W >= 2)       else $error("flmac_core: PIX_W must be at least 2");
      assert (MAX_BEATS >= 1)   else $error("flmac_core: MAX_BEATS must be positive");
      assert (ACC_W > TAU_W)    else $error("flmac_core: accumulator narrower than threshold");
      assert (ACC_W > SUM_W)    else $error("flmac_core: accumulator narrower than tree sum");
   end

   logic [TAU_W-1:0]        tau_q;
   logic [LEAVES*SUM_W-1:0] leaves;
   logic                    t_vld;
   logic                    t_last;
   logic signed [SUM_W-1:0] t_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tau_q <= '0;
      else if (tau_load) tau_q <= tau_value;
   end

   flmac_lane #(
      .LANES (LANES),
      .PIX_W (PIX_W),
      .LEAVES(LEAVES),
      .SUM_W (SUM_W)
   ) u_lane (
      .pix_data(pix_data),
      .wgt_bits(wgt_bits),
      .leaves  (leaves)
   );

   flmac_tree #(
      .LEVELS(LEVELS),
      .SUM_W (SUM_W),
      .PIPE  (PIPE)
   ) u_tree (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (pix_valid),
      .in_last (pix_last),
      .leaves  (leaves),
      .out_vld (t_vld),
      .out_last(t_last),
      .out_sum (t_sum)
   );

   flmac_acc #(
      .SUM_W(SUM_W),
      .TAU_W(TAU_W),
      .ACC_W(ACC_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sum_vld  (t_vld),
      .sum_last (t_last),
      .sum      (t_sum),
      .tau      (tau_q),
      .act_valid(act_valid),
      .act_bit  (act_bit)
   );

endmodule

// File: rtl/flmac_core_chk.sv
// Port-level checker for flmac_core.
module flmac_core_chk #(
   parameter int LANES     = 8,
   parameter int PIX_W     = 8,
   parameter int MAX_BEATS = 64,
   parameter bit PIPE      = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pix_valid,
   input logic                   pix_last,
   input logic [LANES*PIX_W-1:0] pix_data,
   input logic                   act_valid,
   input logic                   act_bit
);

   localparam int LAT   = (PIPE ? flmac_pkg::tree_levels(LANES) : 0) + 1;
   localparam int CNT_W = $clog2(MAX_BEATS + 1) + 1;

   function automatic bit has_min(input logic [LANES*PIX_W-1:0] d);
      bit hit;
      hit = 1'b0;
      for (int j = 0; j < LANES; j++) begin
         if (d[j*PIX_W +: PIX_W] == {1'b1, {(PIX_W-1){1'b0}}}) hit = 1'b1;
      end
      return hit;
   endfunction

   // Delay line of accepted last beats, one stage per cycle of latency.
   logic [LAT-1:0]   last_dly;
   logic [CNT_W-1:0] beat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_dly <= '0;
         beat_cnt <= '0;
      end else begin
         if (LAT > 1) last_dly <= {last_dly[LAT-2:0], pix_valid && pix_last};
         else         last_dly <= {pix_valid && pix_last};
         if (pix_valid) beat_cnt <= pix_last ? '0 : beat_cnt + 1'b1;
      end
   end

   assert_pix_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !has_min(pix_data));

   assert_window_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (beat_cnt < CNT_W'(MAX_BEATS)));

   assert_act_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid == last_dly[LAT-1]);

   assert_act_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> !$isunknown(act_bit));

   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !act_valid);

endmodule

bind flmac_core flmac_core_chk #(
   .LANES    (LANES),
   .PIX_W    (PIX_W),
   .MAX_BEATS(MAX_BEATS),
   .PIPE     (PIPE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pix_valid(pix_valid),
   .pix_last (pix_last),
   .pix_data (pix_data),
   .act_valid(act_valid),
   .act_bit  (act_bit)
);

// File: tb/flmac_core_bench.sv
module flmac_core_bench;

   localparam int LANES     = 8;
   localparam int PIX_W     = 8;
   localparam int TAU_W     = 16;
   localparam int MAX_BEATS = 64;
   localparam bit PIPE      = 1'b1;
   localparam int LAT       = (PIPE ? $clog2(LANES) : 0) + 1;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   pix_valid = 1'b0;
   logic                   pix_last = 1'b0;
   logic [LANES*PIX_W-1:0] pix_data = '0;
   logic [LANES-1:0]       wgt_bits = '0;
   logic                   tau_load = 1'b0;
   logic [TAU_W-1:0]       tau_value = '0;
   logic                   act_valid;
   logic                   act_bit;

   always #2 clk = ~clk;

   flmac_core #(
      .LANES(LANES), .PIX_W(PIX_W), .TAU_W(TAU_W),
      .MAX_BEATS(MAX_BEATS), .PIPE(PIPE)
   ) u_flmac_core (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_last(pix_last),
      .pix_data(pix_data), .wgt_bits(wgt_bits), .tau_load(tau_load),
      .tau_value(tau_value), .act_valid(act_valid), .act_bit(act_bit)
   );

   int    cyc = 0;
   int    errs = 0;
   int    checks = 0;
   int    tau_m = 0;
   bit    done = 1'b0;
   bit    qb[$];
   int    qc[$];
   string qr[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // Output monitor, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && act_valid) begin
         if (qb.size() == 0) begin
            chk(1'b0, "R6 unexpected act_valid", 1, 0);
         end else begin
            bit    eb;
            int    ec;
            string er;
            eb = qb.pop_front();
            ec = qc.pop_front();
            er = qr.pop_front();
            chk(act_bit == eb, er, act_bit, eb);
            chk(cyc == ec, "R6 latency", cyc, ec);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pix_valid = 1'b0;
         pix_last  = 1'b0;
      end
   endtask

   task automatic set_tau(input int v);
      idle(LAT + 2);
      @(negedge clk);
      tau_load  = 1'b1;
      tau_value = TAU_W'(v);
      @(negedge clk);
      tau_load  = 1'b0;
      tau_value = TAU_W'($urandom);
      tau_m     = v;
      idle(2);
   endtask

   // mode 0: random, 1: all +127 w=1, 2: all -127 w=1, 3: all +127 w=0, 4: all -127 w=0
   task automatic run_window(input int nbeats, input int mode, input bit gaps, input string req);
      longint s = 0;
      for (int b = 0; b < nbeats; b++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            pix_valid = 1'b0;
            pix_last  = 1'($urandom);
            pix_data  = {$urandom, $urandom};
            wgt_bits  = LANES'($urandom);
         end
         @(negedge clk);
         pix_valid = 1'b1;
         pix_last  = (b == nbeats - 1);
         for (int j = 0; j < LANES; j++) begin
            int v;
            bit w;
            case (mode)
               1: begin v = 127;  w = 1'b1; end
               2: begin v = -127; w = 1'b1; end
               3: begin v = 127;  w = 1'b0; end
               4: begin v = -127; w = 1'b0; end
               default: begin v = int'($urandom_range(254)) - 127; w = 1'($urandom); end
            endcase
            pix_data[j*PIX_W +: PIX_W] = PIX_W'(v);
            wgt_bits[j] = w;
            s += w ? v : -v;
         end
         if (b == nbeats - 1) begin
            qb.push_back(s >= tau_m);
            qc.push_back(cyc + LAT);
            qr.push_back(req);
         end
      end
   endtask

   // One-beat window: lane 0 carries p with weight w, other lanes zero.
   task automatic single(input int p, input bit w, input string req);
      @(negedge clk);
      pix_valid = 1'b1;
      pix_last  = 1'b1;
      pix_data  = '0;
      wgt_bits  = LANES'($urandom);
      pix_data[PIX_W-1:0] = PIX_W'(p);
      wgt_bits[0] = w;
      qb.push_back((w ? p : -p) >= tau_m);
      qc.push_back(cyc + LAT);
      qr.push_back(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin : stim
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(act_valid == 1'b0, "R10 act_valid in reset", act_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(act_valid == 1'b0, "R10 act_valid after reset", act_valid, 0);

      // R10/R4: threshold defaults to 0; zero sum sits on the boundary.
      single(0, 1'b1, "R10 default tau zero, sum 0 gives 1");
      single(-1, 1'b1, "R10 default tau zero, sum -1 gives 0");
      idle(LAT + 2);

      // R4/R5: equality and one below.
      set_tau(5);
      single(5, 1'b1, "R4 sum equals tau");
      single(4, 1'b1, "R4 sum one below tau");
      // R2: weight 0 negates.
      set_tau(-10);
      single(10, 1'b0, "R2 weight 0 subtracts, equal to tau");
      single(9, 1'b0, "R2 weight 0 subtracts, above tau");
      single(11, 1'b0, "R2 weight 0 subtracts, below tau");
      set_tau(127);
      single(-127, 1'b0, "R2 negation of -127");

      // R9: full-scale windows of MAX_BEATS beats.
      set_tau(32767);
      run_window(MAX_BEATS, 1, 1'b0, "R9 full scale positive");
      run_window(MAX_BEATS, 4, 1'b0, "R9 full scale negated -127");
      set_tau(-32768);
      run_window(MAX_BEATS, 2, 1'b0, "R9 full scale negative");
      run_window(MAX_BEATS, 3, 1'b0, "R9 full scale weight 0");

      // R7: back-to-back windows, including one-beat windows.
      set_tau(0);
      run_window(3, 0, 1'b0, "R7 back-to-back a");
      run_window(1, 0, 1'b0, "R7 back-to-back b");
      run_window(1, 0, 1'b0, "R7 back-to-back c");
      run_window(5, 0, 1'b0, "R7 back-to-back d");

      // R3/R8: random windows with gaps, thresholds changing between groups.
      for (int g = 0; g < 8; g++) begin
         set_tau(int'($urandom_range(600)) - 300);
         for (int w = 0; w < 25; w++) begin
            int n;
            n = ($urandom % 4 == 0) ? int'($urandom_range(MAX_BEATS - 1)) + 1
                                    : int'($urandom_range(5)) + 1;
            run_window(n, 0, 1'b1, "R3 R8 random window");
            if ($urandom % 3 == 0) idle(int'($urandom_range(3)));
         end
      end

      idle(LAT + 4);
      chk(qb.size() == 0, "R6 missing activations", qb.size(), 0);
      finish_up();
   end

endmodule